// File: doc/BRIEF.md
# EEPROM Write-Completion Poller

After a page write, a serial EEPROM stays busy for an internal programming cycle of up to about 5 ms, and during that cycle it refuses (NACKs) every address byte sent to it. This block finds the end of that cycle by probing rather than by waiting out a fixed worst-case delay. It sends START plus the device's write-direction address through an I2C master command interface. A NACK closes the probe with STOP, and the block waits a programmable gap before probing again. The first ACK closes the probe with STOP and raises a ready pulse.

The host loads a 7-bit device address, a gap length in clock cycles and a probe budget, then pulses `start`. The block stays busy until it reports ready or, once the budget is spent, timeout. The number of probes used remains readable until the next start. The gap times the budget should cover the device's worst-case write cycle; at a nominal 100 µs gap, that means at least 50 probes for 5 ms.

The bit-level bus signalling lives in the master behind the command interface. That interface takes one command per `cmd_valid`/`cmd_ready` handshake and returns exactly one `rsp_valid` per command.

Top module: `ack_poll_engine`

## Requirements
- R1: After reset, `busy`, `ready_pulse`, `timeout_pulse` and `cmd_valid` are low and `tries_used` is 0.
- R2: A `start` pulse while idle captures the inputs, clears `tries_used`, raises `busy` on the next cycle and issues a probe command (`cmd_kind` = 0). The probe's `cmd_byte` equals `{dev_addr, 1'b0}`.
- R3: A probe answered with `rsp_ack` = 1 and `rsp_arb_lost` = 0 is followed by a STOP command (`cmd_kind` = 1). When the STOP response arrives, `ready_pulse` is high for one cycle and `busy` falls.
- R4: A probe answered with a NACK is followed by a STOP command. The next probe becomes valid max(`retry_gap`, 1) clock edges after the edge that captured the STOP response.
- R5: A probe response with `rsp_arb_lost` = 1 counts as a failed attempt whatever `rsp_ack` says. It is not followed by STOP, and the next probe obeys the same spacing as R4, measured from the probe response.
- R6: `tries_used` rises by one on each probe response and holds its final value after completion until the next accepted `start`.
- R7: When a failed attempt brings `tries_used` to `retry_limit`, `timeout_pulse` is high for one cycle, `busy` falls and no further probe is issued. A device that acks on the last allowed probe gives ready.
- R8: A `start` with `retry_limit` = 0 gives a one-cycle `timeout_pulse` on the next cycle, with no command issued and `busy` kept low.
- R9: A `start` pulse while busy is ignored: the running poll keeps its captured address, budget and outcome.
- R10: Each run ends in exactly one pulse, either ready or timeout, never both.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind` and `cmd_byte` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a polling run (ignored while busy) |
| dev_addr | input | 7 | Device 7-bit address |
| retry_gap | input | GAP_W | Cycles between one attempt's end and the next probe |
| retry_limit | input | TRY_W | Maximum number of probes |
| busy | output | 1 | Run in progress |
| ready_pulse | output | 1 | One-cycle: device acknowledged |
| timeout_pulse | output | 1 | One-cycle: budget exhausted |
| tries_used | output | TRY_W | Probes answered in the current or last run |
| cmd_valid | output | 1 | Command to the I2C master is valid |
| cmd_kind | output | 1 | 0 = START plus address byte, 1 = STOP |
| cmd_byte | output | 8 | Address byte for a probe |
| cmd_ready | input | 1 | Master accepts the command |
| rsp_valid | input | 1 | Master completed the last accepted command |
| rsp_ack | input | 1 | Address byte was acknowledged |
| rsp_arb_lost | input | 1 | Arbitration was lost during the probe |

## Verification
The assertions assume that the master returns exactly one `rsp_valid` per accepted command and never one unprompted. They also assume that `rsp_ack`/`rsp_arb_lost` are meaningful only with `rsp_valid`, and that reset lasts at least one clock. The bench's master model keeps within those assumptions: it answers each accepted command once, after a fixed latency, and holds `cmd_ready` low for a chosen stall before accepting. The bench scripts which probe acks and which probe loses arbitration, including a probe that both acks and loses arbitration. From that script it predicts the outcome, the probe and STOP counts, and the exact gap between a response and the next probe.

// File: rtl/apoll_pkg.sv
// Package: shared encodings for the EEPROM write-completion poller.
// Assumes a 7-bit device address and write-direction probes only.
package apoll_pkg;

    localparam int ADDR_W = 7;

    // Command kinds presented to the I2C master.
    typedef enum logic {
        CMD_PROBE = 1'b0,
        CMD_STOP  = 1'b1
    } cmd_kind_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROBE     = 3'd1,
        ST_PROBE_RSP = 3'd2,
        ST_STOP      = 3'd3,
        ST_STOP_RSP  = 3'd4,
        ST_GAP       = 3'd5
    } seq_state_e;

endpackage

// File: rtl/apoll_gap_timer.sv
// Module: apoll_gap_timer
// Counts the retry gap. A load sets the count so that `expired` is seen
// max(period,1) cycles later. Assumes load is only pulsed on entry to the gap.
module apoll_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] period,
    output logic             expired
);

    logic [GAP_W-1:0] cnt_q;
    logic [GAP_W-1:0] load_val;

    // Load value: a zero period behaves as a one-cycle gap.
    always_comb begin
        load_val = (period == '0) ? '0 : period - 1'b1;
    end

    // Down-counter that rests at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R4: a running gap count only moves downward by one per cycle.
    assert_gap_descends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/apoll_try_counter.sv
// Module: apoll_try_counter
// Counts answered probes and holds the captured budget. Flags whether the
// attempt now being answered is the last allowed one and whether the budget is spent.
// Assumes clr and inc are never asserted together.
module apoll_try_counter #(
    parameter int TRY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [TRY_W-1:0] limit_in,
    output logic [TRY_W-1:0] count,
    output logic             final_try,
    output logic             spent
);

    localparam int EXT_W = TRY_W + 1;

    logic [TRY_W-1:0] count_q;
    logic [TRY_W-1:0] limit_q;
    logic [EXT_W-1:0] next_ext;

    // Attempt counter: cleared on accepted start, stepped per probe response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Budget capture at accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (clr) begin
            limit_q <= limit_in;
        end
    end

    // Budget comparisons, widened so a full-scale limit does not wrap.
    always_comb begin
        next_ext  = {1'b0, count_q} + 1'b1;
        final_try = (next_ext >= {1'b0, limit_q});
        spent     = (count_q >= limit_q);
    end

    assign count = count_q;

    // R6: the count only steps up by one or returns to zero.
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> ((count_q == $past(count_q) + 1'b1) || (count_q == '0)));

    // R7: the count never passes the captured budget.
    assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= limit_q);

endmodule

// File: rtl/apoll_seq.sv
// Module: apoll_seq
// Control sequencer: probe, await response, close with STOP when the bus is
// owned, then finish or wait a gap. Assumes the master answers each
// accepted command with exactly one rsp_valid.
module apoll_seq
    import apoll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  logic      zero_budget,
    input  logic      final_try,
    input  logic      budget_spent,
    input  logic      gap_expired,
    input  logic      cmd_ready,
    input  logic      rsp_valid,
    input  logic      rsp_ack,
    input  logic      rsp_arb_lost,
    output logic      cmd_valid,
    output cmd_kind_e cmd_kind,
    output logic      busy,
    output logic      ready_pulse,
    output logic      timeout_pulse,
    output logic      take_cfg,
    output logic      cnt_inc,
    output logic      gap_load
);

    seq_state_e state_q, state_d;
    logic       ok_q, ok_d;
    logic       ready_q, timeout_q;
    logic       set_ready, set_timeout;
    logic       probe_ok;

    assign probe_ok = rsp_ack && !rsp_arb_lost;

    // Next-state and one-shot decisions.
    always_comb begin
        state_d     = state_q;
        ok_d        = ok_q;
        gap_load    = 1'b0;
        set_ready   = 1'b0;
        set_timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (zero_budget) set_timeout = 1'b1;
                    else             state_d     = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (cmd_ready) state_d = ST_PROBE_RSP;
            end
            ST_PROBE_RSP: begin
                if (rsp_valid) begin
                    if (rsp_arb_lost) begin
                        if (final_try) begin
                            set_timeout = 1'b1;
                            state_d     = ST_IDLE;
                        end else begin
                            gap_load = 1'b1;
                            state_d  = ST_GAP;
                        end
                    end else begin
                        ok_d    = probe_ok;
                        state_d = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (cmd_ready) state_d = ST_STOP_RSP;
            end
            ST_STOP_RSP: begin
                if (rsp_valid) begin
                    if (ok_q) begin
                        set_ready = 1'b1;
                        state_d   = ST_IDLE;
                    end else if (budget_spent) begin
                        set_timeout = 1'b1;
                        state_d     = ST_IDLE;
                    end else begin
                        gap_load = 1'b1;
                        state_d  = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (gap_expired) state_d = ST_PROBE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, outcome flag and registered completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ok_q      <= 1'b0;
            ready_q   <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ok_q      <= ok_d;
            ready_q   <= set_ready;
            timeout_q <= set_timeout;
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign cmd_valid     = (state_q == ST_PROBE) || (state_q == ST_STOP);
    assign cmd_kind      = (state_q == ST_STOP) ? CMD_STOP : CMD_PROBE;
    assign take_cfg      = go && (state_q == ST_IDLE);
    assign cnt_inc       = (state_q == ST_PROBE_RSP) && rsp_valid;
    assign ready_pulse   = ready_q;
    assign timeout_pulse = timeout_q;

    // R3: ready lasts a single cycle.
    assert_ready_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_pulse |=> !ready_pulse);

    // R7: timeout lasts a single cycle.
    assert_timeout_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    // R10: the two outcomes never coincide.
    assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_pulse && timeout_pulse));

    // R3: ready is reported only once the run has left the busy states.
    assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_pulse |-> !busy);

endmodule

// File: rtl/ack_poll_engine.sv
// Module: ack_poll_engine (top)
// Detects the end of an EEPROM internal write cycle by address probing
// through an I2C master command interface. Captures address, gap and budget
// on an accepted start; the inputs may change freely afterwards.
module ack_poll_engine
    import apoll_pkg::*;
#(
    parameter int TRY_W = 8,
    parameter int GAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [6:0]        dev_addr,
    input  logic [GAP_W-1:0]  retry_gap,
    input  logic [TRY_W-1:0]  retry_limit,
    output logic              busy,
    output logic              ready_pulse,
    output logic              timeout_pulse,
    output logic [TRY_W-1:0]  tries_used,
    output logic              cmd_valid,
    output logic              cmd_kind,
    output logic [7:0]        cmd_byte,
    input  logic              cmd_ready,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic              rsp_arb_lost
);

    logic [ADDR_W-1:0] addr_q;
    logic [GAP_W-1:0]  gap_q;
    logic              take_cfg, cnt_inc, gap_load, gap_expired;
    logic              final_try, spent;
    cmd_kind_e         kind_e;

    // Address and gap capture at accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            gap_q  <= '0;
        end else if (take_cfg) begin
            addr_q <= dev_addr;
            gap_q  <= retry_gap;
        end
    end

    apoll_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (start),
        .zero_budget   (retry_limit == '0),
        .final_try     (final_try),
        .budget_spent  (spent),
        .gap_expired   (gap_expired),
        .cmd_ready     (cmd_ready),
        .rsp_valid     (rsp_valid),
        .rsp_ack       (rsp_ack),
        .rsp_arb_lost  (rsp_arb_lost),
        .cmd_valid     (cmd_valid),
        .cmd_kind      (kind_e),
        .busy          (busy),
        .ready_pulse   (ready_pulse),
        .timeout_pulse (timeout_pulse),
        .take_cfg      (take_cfg),
        .cnt_inc       (cnt_inc),
        .gap_load      (gap_load)
    );

    apoll_try_counter #(.TRY_W(TRY_W)) u_tries (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (take_cfg),
        .inc       (cnt_inc),
        .limit_in  (retry_limit),
        .count     (tries_used),
        .final_try (final_try),
        .spent     (spent)
    );

    apoll_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .period  (gap_q),
        .expired (gap_expired)
    );

    assign cmd_kind = kind_e;
    assign cmd_byte = {addr_q, 1'b0};

    // R11: a stalled command is held unchanged.
    assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_byte)));

    // R9: the probe address stays fixed for the whole run.
    assert_addr_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_byte));

    // R1: no command leaves an idle engine.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

endmodule

// File: tb/sim_ack_poll_engine.sv
module sim_ack_poll_engine;

    localparam int TRY_W = 8;
    localparam int GAP_W = 16;
    localparam int LAT   = 3;
    localparam int NVEC  = 12;

    typedef struct packed {
        logic [7:0] mx;
        logic [7:0] iv;
        logic [7:0] ak;
        logic [7:0] ar;
        logic       rdy;
        logic [7:0] tr;
        logic [7:0] st;
    } vec_t;

    // limit, gap, acking probe (0 = never), arb-lost probe (0 = none),
    // expect ready, expect tries, expect STOP count
    localparam vec_t VECS [NVEC] = '{
        '{8'd8, 8'd4, 8'd1, 8'd0, 1'b1, 8'd1, 8'd1},
        '{8'd8, 8'd5, 8'd3, 8'd0, 1'b1, 8'd3, 8'd3},
        '{8'd4, 8'd3, 8'd0, 8'd0, 1'b0, 8'd4, 8'd4},
        '{8'd4, 8'd2, 8'd4, 8'd0, 1'b1, 8'd4, 8'd4},
        '{8'd4, 8'd2, 8'd5, 8'd0, 1'b0, 8'd4, 8'd4},
        '{8'd6, 8'd3, 8'd3, 8'd2, 1'b1, 8'd3, 8'd2},
        '{8'd3, 8'd0, 8'd0, 8'd3, 1'b0, 8'd3, 8'd2},
        '{8'd1, 8'd7, 8'd1, 8'd0, 1'b1, 8'd1, 8'd1},
        '{8'd5, 8'd1, 8'd2, 8'd1, 1'b1, 8'd2, 8'd1},
        '{8'd6, 8'd2, 8'd2, 8'd2, 1'b1, 8'd3, 8'd2},
        '{8'd0, 8'd3, 8'd1, 8'd0, 1'b0, 8'd0, 8'd0},
        '{8'd2, 8'd9, 8'd0, 8'd1, 1'b0, 8'd2, 8'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [6:0]        dev_addr = '0;
    logic [GAP_W-1:0]  retry_gap = '0;
    logic [TRY_W-1:0]  retry_limit = '0;
    logic              busy, ready_pulse, timeout_pulse;
    logic [TRY_W-1:0]  tries_used;
    logic              cmd_valid, cmd_kind;
    logic [7:0]        cmd_byte;
    logic              cmd_ready = 1'b0;
    logic              rsp_valid = 1'b0;
    logic              rsp_ack = 1'b0;
    logic              rsp_arb_lost = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // master model state and configuration
    logic [6:0] m_addr = '0;
    int m_ack_at = 0, m_arb_at = 0, m_stall = 0, m_gap = 1;
    int n_probe = 0, n_stop = 0, n_ready = 0, n_timeout = 0;
    int bad_gap = 0, bad_byte = 0;
    int last_rsp = 0, delay = 0, wait_ct = 0;
    bit inflight = 0, seen = 0;

    always #5 clk = ~clk;

    ack_poll_engine #(.TRY_W(TRY_W), .GAP_W(GAP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
        .retry_gap(retry_gap), .retry_limit(retry_limit), .busy(busy),
        .ready_pulse(ready_pulse), .timeout_pulse(timeout_pulse),
        .tries_used(tries_used), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_byte(cmd_byte), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
        .rsp_ack(rsp_ack), .rsp_arb_lost(rsp_arb_lost)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // I2C master model, driven on the falling edge
    always @(negedge clk) begin
        cyc++;
        cmd_ready = 1'b0;
        if (!rst_n) begin
            rsp_valid = 1'b0; inflight = 0; seen = 0;
        end else begin
            if (ready_pulse)   n_ready++;
            if (timeout_pulse) n_timeout++;
            if (rsp_valid) begin
                rsp_valid = 1'b0;
                inflight  = 0;
            end else if (inflight) begin
                if (delay <= 1) begin
                    rsp_valid = 1'b1;
                    last_rsp  = cyc;
                end else begin
                    delay--;
                end
            end else if (cmd_valid) begin
                if (!seen) begin
                    seen    = 1;
                    wait_ct = m_stall;
                    if (cmd_kind == 1'b0) begin
                        if (n_probe > 0 && (cyc - last_rsp) != m_gap) bad_gap++;
                        if (cmd_byte != {m_addr, 1'b0}) bad_byte++;
                    end
                end
                if (wait_ct == 0) begin
                    cmd_ready = 1'b1;
                    seen      = 0;
                    inflight  = 1;
                    delay     = LAT;
                    if (cmd_kind == 1'b0) begin
                        n_probe++;
                        rsp_ack      = (m_ack_at != 0) && (n_probe >= m_ack_at);
                        rsp_arb_lost = (n_probe == m_arb_at);
                    end else begin
                        n_stop++;
                        rsp_ack      = 1'b1;
                        rsp_arb_lost = 1'b0;
                    end
                end else begin
                    wait_ct--;
                end
            end
        end
    end

    task automatic setup_run(input int mx, input int iv, input int ak, input int ar,
                             input int st, input logic [6:0] a);
        @(negedge clk);
        m_addr = a; m_ack_at = ak; m_arb_at = ar; m_stall = st;
        m_gap = ((iv == 0) ? 1 : iv) + 1;
        n_probe = 0; n_stop = 0; n_ready = 0; n_timeout = 0;
        bad_gap = 0; bad_byte = 0;
        dev_addr = a; retry_gap = GAP_W'(iv); retry_limit = TRY_W'(mx);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 5000; k++) begin
            if (n_ready + n_timeout > 0) break;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic judge(input string tag, input bit rdy, input int tr, input int st);
        check(n_ready == int'(rdy) && n_timeout == int'(!rdy), {tag, " R3/R7 outcome"},
              n_ready, int'(rdy));
        check(n_ready + n_timeout == 1, {tag, " R10 single outcome"}, n_ready + n_timeout, 1);
        check(int'(tries_used) == tr, {tag, " R6 tries_used"}, int'(tries_used), tr);
        check(n_probe == tr, {tag, " R2 probe count"}, n_probe, tr);
        check(n_stop == st, {tag, " R5 stop count"}, n_stop, st);
        check(bad_gap == 0, {tag, " R4 gap spacing"}, bad_gap, 0);
        check(bad_byte == 0, {tag, " R2 address byte"}, bad_byte, 0);
        check(busy == 1'b0, {tag, " R3 busy low at end"}, int'(busy), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && !ready_pulse && !timeout_pulse && !cmd_valid && tries_used == '0,
              "R1 reset outputs", int'({busy, ready_pulse, timeout_pulse, cmd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !cmd_valid, "R1 idle after reset", int'(busy), 0);

        // table of vectors
        for (int i = 0; i < NVEC; i++) begin
            setup_run(int'(VECS[i].mx), int'(VECS[i].iv), int'(VECS[i].ak),
                      int'(VECS[i].ar), 0, 7'(7'h50 + i));
            if (VECS[i].mx == 0) begin
                // R8: immediate timeout, no busy
                check(timeout_pulse && !busy, "R8 zero budget timeout", int'(timeout_pulse), 1);
            end else begin
                check(busy, "R2 busy after start", int'(busy), 1);
            end
            wait_done();
            judge($sformatf("vec%0d", i), VECS[i].rdy, int'(VECS[i].tr), int'(VECS[i].st));
        end

        // R6: count holds after completion
        repeat (20) @(negedge clk);
        check(int'(tries_used) == 2, "R6 tries_used holds", int'(tries_used), 2);

        // R11: stalled command acceptance
        setup_run(5, 3, 2, 0, 3, 7'h3c);
        wait_done();
        judge("stall R11", 1'b1, 2, 2);

        // R9: start while busy is ignored
        setup_run(5, 6, 3, 0, 0, 7'h51);
        repeat (4) @(negedge clk);
        dev_addr = 7'h22; retry_limit = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        judge("restart R9", 1'b1, 3, 3);

        // R2: new start clears the count
        setup_run(3, 2, 1, 0, 0, 7'h11);
        check(tries_used == '0, "R2 count cleared on start", int'(tries_used), 0);
        wait_done();
        judge("clear R2", 1'b1, 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

endmodule